// File: doc/BRIEF.md
# 8b/10b Transmission Character Encoder

This block turns a stream of bytes, each tagged as data or as a control symbol, into 10-bit transmission characters. It tracks DC balance through a running disparity bit. The low five bits of the byte map to a six-bit sub-block and the high three bits map to a four-bit sub-block. The output word is arranged so that bit 0 is the first bit on the line. The result leaves through a three-stage register pipeline. A word presented in cycle n appears on the outputs in cycle n+3.

The caller can replace the tracked disparity with an external value. The replacement value is presented two cycles after the byte it applies to, so that it reaches the stage that chooses the polarity. When there is no payload the block can fill the gap with comma symbols of the correct polarity. A combinational chain output gives the disparity that results from the word now being encoded. Several encoders that each handle one byte of a wide word can therefore pass disparity from one to the next within a single clock.

Top module: `sym8b10b_encoder`

## Requirements
- R1: Every emitted word follows the standard 8b/10b code tables. Byte bits [4:0] are x and bits [7:5] are y in the symbol name Dx.y or Kx.y. Output bits [5:0] are the six-bit sub-block abcdei, with a in bit 0. Output bits [9:6] are fghj, with f in bit 6.
- R2: While disp_force_i is high, the value on disp_i (1 = positive) replaces the tracked disparity for the word in the selection stage. With disp_i = 1 the emitted word has at most five ones.
- R3: A word sampled at a rising edge with word_en_i or fill_en_i high shows code_vld_o high, with its code, after the third rising edge following that sample.
- R4: Without forcing, each word is encoded against the disparity left by the previous word. disp_o then reads 1 after a word with six ones and 0 after a word with four ones, and is unchanged after a word with five ones.
- R5: With is_ctrl_i high, the twelve control symbols K28.0 to K28.7, K23.7, K27.7, K29.7 and K30.7 are encoded with ctrl_err_o low.
- R6: With is_ctrl_i high and any other byte, ctrl_err_o is high alongside the word, and the code is the data encoding of that byte.
- R7: With word_en_i low and fill_en_i high, the block emits K28.5 in the polarity set by the running disparity, and updates the disparity as it does for any word.
- R8: With word_en_i high, fill_en_i is ignored and the presented byte is encoded.
- R9: A cycle with no word and no forcing gives code_vld_o low three cycles later and leaves disp_o unchanged.
- R10: A data symbol with y = 7 uses the alternate fghj form for x = 17, 18 or 20 when disparity is negative, and for x = 11, 13 or 14 when it is positive.
- R11: disp_chain_o gives, within the current cycle, the disparity after the word in the selection stage. This is the value disp_o takes at the next edge.
- R12: After synchronous reset, code_vld_o and ctrl_err_o are low and disp_o is 0 (negative).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| is_ctrl_i | input | 1 | Byte is a control symbol |
| word_en_i | input | 1 | Byte is present this cycle |
| fill_en_i | input | 1 | Insert comma when no byte is present |
| byte_i | input | 8 | Byte to encode |
| disp_i | input | 1 | External disparity, 1 = positive |
| disp_force_i | input | 1 | Use disp_i in the selection stage |
| code_o | output | 10 | Encoded word, bit 0 sent first |
| code_vld_o | output | 1 | code_o holds a new word |
| ctrl_err_o | output | 1 | Requested control symbol does not exist |
| disp_o | output | 1 | Registered running disparity |
| disp_chain_o | output | 1 | Disparity after the word being selected (combinational) |

## Verification
On every cycle the assertions check that each emitted word carries four to six ones, and that the sign of disp_o agrees with that weight. They also check that forcing positive disparity never yields a six-one word, that idle cycles leave the disparity alone, that the valid flag follows the input enables three cycles later, and that the error flag appears only with a word. Whether each symbol matches the code table, whether the alternate x.7 form is chosen, whether comma fill alternates in polarity, and whether the chain output is correct can only be shown by the bench. It does this with known code words and with directed streams.

// File: rtl/enc8b10b_pkg.sv
package enc8b10b_pkg;

  localparam int BYTE_W = 8;
  localparam int LO_W   = 5;
  localparam int HI_W   = BYTE_W - LO_W;
  localparam int SIX_W  = LO_W + 1;
  localparam int FOUR_W = HI_W + 1;
  localparam int CODE_W = SIX_W + FOUR_W;

  localparam logic [FOUR_W-1:0] ALT7_NEG = 4'b0111;

  // Precomputed sub-block information, negative-disparity form,
  // literals written with the first transmitted bit as MSB.
  typedef struct packed {
    logic [SIX_W-1:0]  six;
    logic              six_flip;
    logic              six_unbal;
    logic [FOUR_W-1:0] four;
    logic              four_flip;
    logic              four_unbal;
    logic              alt_neg;
    logic              alt_pos;
    logic              alt_always;
    logic              ctrl_bad;
  } sub_t;

  function automatic logic [SIX_W-1:0] six_neg(input logic [LO_W-1:0] x);
    logic [SIX_W-1:0] r;
    case (x)
      5'd0:  r = 6'b100111;  5'd1:  r = 6'b011101;
      5'd2:  r = 6'b101101;  5'd3:  r = 6'b110001;
      5'd4:  r = 6'b110101;  5'd5:  r = 6'b101001;
      5'd6:  r = 6'b011001;  5'd7:  r = 6'b111000;
      5'd8:  r = 6'b111001;  5'd9:  r = 6'b100101;
      5'd10: r = 6'b010101;  5'd11: r = 6'b110100;
      5'd12: r = 6'b001101;  5'd13: r = 6'b101100;
      5'd14: r = 6'b011100;  5'd15: r = 6'b010111;
      5'd16: r = 6'b011011;  5'd17: r = 6'b100011;
      5'd18: r = 6'b010011;  5'd19: r = 6'b110010;
      5'd20: r = 6'b001011;  5'd21: r = 6'b101010;
      5'd22: r = 6'b011010;  5'd23: r = 6'b111010;
      5'd24: r = 6'b110011;  5'd25: r = 6'b100110;
      5'd26: r = 6'b010110;  5'd27: r = 6'b110110;
      5'd28: r = 6'b001110;  5'd29: r = 6'b101110;
      5'd30: r = 6'b011110;  default: r = 6'b101011;
    endcase
    return r;
  endfunction

  function automatic logic [FOUR_W-1:0] four_data(input logic [HI_W-1:0] y);
    logic [FOUR_W-1:0] r;
    case (y)
      3'd0: r = 4'b1011;  3'd1: r = 4'b1001;
      3'd2: r = 4'b0101;  3'd3: r = 4'b1100;
      3'd4: r = 4'b1101;  3'd5: r = 4'b1010;
      3'd6: r = 4'b0110;  default: r = 4'b1110;
    endcase
    return r;
  endfunction

  function automatic logic [FOUR_W-1:0] four_ctrl(input logic [HI_W-1:0] y);
    logic [FOUR_W-1:0] r;
    case (y)
      3'd0: r = 4'b1011;  3'd1: r = 4'b0110;
      3'd2: r = 4'b1010;  3'd3: r = 4'b1100;
      3'd4: r = 4'b1101;  3'd5: r = 4'b0101;
      3'd6: r = 4'b1001;  default: r = 4'b0111;
    endcase
    return r;
  endfunction

  function automatic logic ctrl_exists(input logic [BYTE_W-1:0] b);
    logic [LO_W-1:0] x;
    logic [HI_W-1:0] y;
    x = b[LO_W-1:0];
    y = b[BYTE_W-1:LO_W];
    return (x == 5'd28) ||
           ((y == 3'd7) && (x == 5'd23 || x == 5'd27 || x == 5'd29 || x == 5'd30));
  endfunction

  function automatic logic [SIX_W-1:0] rev6(input logic [SIX_W-1:0] v);
    logic [SIX_W-1:0] r;
    for (int i = 0; i < SIX_W; i++) r[i] = v[SIX_W-1-i];
    return r;
  endfunction

  function automatic logic [FOUR_W-1:0] rev4(input logic [FOUR_W-1:0] v);
    logic [FOUR_W-1:0] r;
    for (int i = 0; i < FOUR_W; i++) r[i] = v[FOUR_W-1-i];
    return r;
  endfunction

endpackage

// File: rtl/enc8b10b_capture.sv
module enc8b10b_capture
  import enc8b10b_pkg::*;
#(
  parameter logic [BYTE_W-1:0] FILL_BYTE = 8'hBC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              is_ctrl_i,
  input  logic              word_en_i,
  input  logic              fill_en_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              a_vld,
  output logic              a_ctrl,
  output logic [BYTE_W-1:0] a_byte
);

  always_ff @(posedge clk) begin
    if (rst) begin
      a_vld  <= 1'b0;
      a_ctrl <= 1'b0;
      a_byte <= '0;
    end else begin
      a_vld <= word_en_i | fill_en_i;
      if (word_en_i) begin
        a_ctrl <= is_ctrl_i;
        a_byte <= byte_i;
      end else if (fill_en_i) begin
        a_ctrl <= 1'b1;
        a_byte <= FILL_BYTE;
      end
    end
  end

  AST_EN_PRIORITY: assert property (@(posedge clk) disable iff (rst)
    word_en_i |=> (a_vld && a_byte == $past(byte_i) && a_ctrl == $past(is_ctrl_i))); // R8

  AST_FILL_WORD: assert property (@(posedge clk) disable iff (rst)
    (!word_en_i && fill_en_i) |=> (a_vld && a_ctrl && a_byte == FILL_BYTE)); // R7

endmodule

// File: rtl/enc8b10b_classify.sv
module enc8b10b_classify
  import enc8b10b_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              a_vld,
  input  logic              a_ctrl,
  input  logic [BYTE_W-1:0] a_byte,
  output logic              b_vld,
  output sub_t              b_sub
);

  logic [LO_W-1:0] x;
  logic [HI_W-1:0] y;
  logic            k_ok;
  logic            k28;
  sub_t            sub_d;

  always_comb begin
    x     = a_byte[LO_W-1:0];
    y     = a_byte[BYTE_W-1:LO_W];
    k_ok  = a_ctrl && ctrl_exists(a_byte);
    k28   = k_ok && (x == 5'd28);
    sub_d = '0;
    sub_d.six        = k28 ? 6'b001111 : six_neg(x);
    sub_d.six_unbal  = ($countones(sub_d.six) != 3);
    sub_d.six_flip   = sub_d.six_unbal || (!k28 && x == 5'd7);
    sub_d.four       = k_ok ? four_ctrl(y) : four_data(y);
    sub_d.four_unbal = ($countones(sub_d.four) != 2);
    sub_d.four_flip  = k_ok || sub_d.four_unbal || (y == 3'd3);
    sub_d.alt_always = k_ok && (y == 3'd7);
    sub_d.alt_neg    = !k_ok && (y == 3'd7) &&
                       (x == 5'd17 || x == 5'd18 || x == 5'd20);
    sub_d.alt_pos    = !k_ok && (y == 3'd7) &&
                       (x == 5'd11 || x == 5'd13 || x == 5'd14);
    sub_d.ctrl_bad   = a_ctrl && !k_ok;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      b_vld <= 1'b0;
      b_sub <= '0;
    end else begin
      b_vld <= a_vld;
      if (a_vld) b_sub <= sub_d;
    end
  end

  AST_ALT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    b_vld |-> $onehot0({b_sub.alt_neg, b_sub.alt_pos, b_sub.alt_always})); // R10

endmodule

// File: rtl/enc8b10b_emit.sv
module enc8b10b_emit
  import enc8b10b_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              b_vld,
  input  sub_t              b_sub,
  input  logic              disp_i,
  input  logic              disp_force_i,
  output logic [CODE_W-1:0] code_o,
  output logic              code_vld_o,
  output logic              ctrl_err_o,
  output logic              disp_o,
  output logic              disp_chain_o
);

  logic              rd_q;
  logic              rd_eff;
  logic              rd_mid;
  logic              rd_end;
  logic              rd_next;
  logic              use_alt;
  logic [SIX_W-1:0]  six_v;
  logic [FOUR_W-1:0] four_sel;
  logic [FOUR_W-1:0] four_v;
  logic              four_unb;
  logic              four_flp;

  always_comb begin
    rd_eff   = disp_force_i ? disp_i : rd_q;
    six_v    = (rd_eff && b_sub.six_flip) ? ~b_sub.six : b_sub.six;
    rd_mid   = rd_eff ^ b_sub.six_unbal;
    use_alt  = b_sub.alt_always || (b_sub.alt_neg && !rd_mid) ||
               (b_sub.alt_pos && rd_mid);
    four_sel = use_alt ? ALT7_NEG : b_sub.four;
    four_unb = use_alt ? 1'b1 : b_sub.four_unbal;
    four_flp = use_alt ? 1'b1 : b_sub.four_flip;
    four_v   = (rd_mid && four_flp) ? ~four_sel : four_sel;
    rd_end   = rd_mid ^ four_unb;
    rd_next  = b_vld ? rd_end : rd_eff;
  end

  assign disp_chain_o = rd_next;
  assign disp_o       = rd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q       <= 1'b0;
      code_o     <= '0;
      code_vld_o <= 1'b0;
      ctrl_err_o <= 1'b0;
    end else begin
      rd_q       <= rd_next;
      code_vld_o <= b_vld;
      ctrl_err_o <= b_vld && b_sub.ctrl_bad;
      if (b_vld) code_o <= {rev4(four_v), rev6(six_v)};
    end
  end

  AST_CODE_WEIGHT: assert property (@(posedge clk) disable iff (rst)
    code_vld_o |-> ($countones(code_o) >= 4 && $countones(code_o) <= 6)); // R1

  AST_HEAVY_POS: assert property (@(posedge clk) disable iff (rst)
    (code_vld_o && $countones(code_o) == 6) |-> disp_o); // R4

  AST_LIGHT_NEG: assert property (@(posedge clk) disable iff (rst)
    (code_vld_o && $countones(code_o) == 4) |-> !disp_o); // R4

  AST_FORCE_POS: assert property (@(posedge clk) disable iff (rst)
    (b_vld && disp_force_i && disp_i) |=> (code_vld_o && $countones(code_o) <= 5)); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!b_vld && !disp_force_i) |=> (!code_vld_o && $stable(disp_o))); // R9

endmodule

// File: rtl/sym8b10b_encoder.sv
module sym8b10b_encoder
  import enc8b10b_pkg::*;
#(
  parameter logic [BYTE_W-1:0] FILL_BYTE = 8'hBC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              is_ctrl_i,
  input  logic              word_en_i,
  input  logic              fill_en_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              disp_i,
  input  logic              disp_force_i,
  output logic [CODE_W-1:0] code_o,
  output logic              code_vld_o,
  output logic              ctrl_err_o,
  output logic              disp_o,
  output logic              disp_chain_o
);

  localparam int PIPE_DEPTH = 3;

  logic              a_vld;
  logic              a_ctrl;
  logic [BYTE_W-1:0] a_byte;
  logic              b_vld;
  sub_t              b_sub;
  logic [1:0]        since_rst;

  enc8b10b_capture #(.FILL_BYTE(FILL_BYTE)) u_capture (
    .clk       (clk),
    .rst       (rst),
    .is_ctrl_i (is_ctrl_i),
    .word_en_i (word_en_i),
    .fill_en_i (fill_en_i),
    .byte_i    (byte_i),
    .a_vld     (a_vld),
    .a_ctrl    (a_ctrl),
    .a_byte    (a_byte)
  );

  enc8b10b_classify u_classify (
    .clk    (clk),
    .rst    (rst),
    .a_vld  (a_vld),
    .a_ctrl (a_ctrl),
    .a_byte (a_byte),
    .b_vld  (b_vld),
    .b_sub  (b_sub)
  );

  enc8b10b_emit u_emit (
    .clk          (clk),
    .rst          (rst),
    .b_vld        (b_vld),
    .b_sub        (b_sub),
    .disp_i       (disp_i),
    .disp_force_i (disp_force_i),
    .code_o       (code_o),
    .code_vld_o   (code_vld_o),
    .ctrl_err_o   (ctrl_err_o),
    .disp_o       (disp_o),
    .disp_chain_o (disp_chain_o)
  );

  // Cycles since reset, saturating at the pipeline depth; used by checks only.
  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst != 2'(PIPE_DEPTH)) since_rst <= since_rst + 2'd1;
  end

  AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'(PIPE_DEPTH)) |->
      (code_vld_o == $past(word_en_i || fill_en_i, 3))); // R3

  AST_ERR_WITH_WORD: assert property (@(posedge clk) disable iff (rst)
    ctrl_err_o |-> code_vld_o); // R6

endmodule

// File: tb/test_sym8b10b_encoder.sv
module test_sym8b10b_encoder;

  logic       clk = 1'b0;
  logic       rst;
  logic       is_ctrl_i, word_en_i, fill_en_i, disp_i, disp_force_i;
  logic [7:0] byte_i;
  logic [9:0] code_o;
  logic       code_vld_o, ctrl_err_o, disp_o, disp_chain_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  sym8b10b_encoder i_sym8b10b_encoder (
    .clk(clk), .rst(rst), .is_ctrl_i(is_ctrl_i), .word_en_i(word_en_i),
    .fill_en_i(fill_en_i), .byte_i(byte_i), .disp_i(disp_i),
    .disp_force_i(disp_force_i), .code_o(code_o), .code_vld_o(code_vld_o),
    .ctrl_err_o(ctrl_err_o), .disp_o(disp_o), .disp_chain_o(disp_chain_o)
  );

  // {ctrl, byte, forced disparity, code written abcdeifghj, disparity after}
  localparam int NVEC = 16;
  localparam logic [20:0] VEC [NVEC] = '{
    {1'b0, 8'h00, 1'b0, 10'b1001110100, 1'b0},  // D0.0
    {1'b0, 8'h00, 1'b1, 10'b0110001011, 1'b1},  // D0.0
    {1'b1, 8'hBC, 1'b0, 10'b0011111010, 1'b1},  // K28.5
    {1'b1, 8'hBC, 1'b1, 10'b1100000101, 1'b0},  // K28.5
    {1'b0, 8'hB5, 1'b0, 10'b1010101010, 1'b0},  // D21.5
    {1'b0, 8'h67, 1'b0, 10'b1110001100, 1'b0},  // D7.3
    {1'b0, 8'h67, 1'b1, 10'b0001110011, 1'b1},  // D7.3
    {1'b0, 8'hF1, 1'b0, 10'b1000110111, 1'b1},  // D17.7 alternate
    {1'b0, 8'hF1, 1'b1, 10'b1000110001, 1'b0},  // D17.7 primary
    {1'b0, 8'hEB, 1'b1, 10'b1101001000, 1'b0},  // D11.7 alternate
    {1'b0, 8'hEB, 1'b0, 10'b1101001110, 1'b1},  // D11.7 primary
    {1'b1, 8'hFC, 1'b0, 10'b0011111000, 1'b0},  // K28.7
    {1'b1, 8'hF7, 1'b0, 10'b1110101000, 1'b0},  // K23.7
    {1'b0, 8'h23, 1'b1, 10'b1100011001, 1'b1},  // D3.1
    {1'b1, 8'h1C, 1'b1, 10'b1100001011, 1'b1},  // K28.0
    {1'b0, 8'h9F, 1'b0, 10'b1010110010, 1'b0}   // D31.4
  };

  function automatic logic [9:0] wire_order(input logic [9:0] v);
    logic [9:0] r;
    for (int i = 0; i < 10; i++) r[i] = v[9-i];
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Byte in cycle n, forced disparity in cycle n+2, result read in cycle n+3.
  task automatic send_forced(input logic c, input logic [7:0] b, input logic rd);
    @(negedge clk);
    word_en_i = 1'b1; is_ctrl_i = c; byte_i = b;
    @(negedge clk);
    word_en_i = 1'b0; is_ctrl_i = 1'b0;
    @(negedge clk);
    disp_force_i = 1'b1; disp_i = rd;
    @(negedge clk);
    disp_force_i = 1'b0; disp_i = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; is_ctrl_i = 1'b0; word_en_i = 1'b0; fill_en_i = 1'b0;
    byte_i = 8'h00; disp_i = 1'b0; disp_force_i = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R12 valid after reset", code_vld_o, 0);
    chk("R12 disparity after reset", disp_o, 0);
    chk("R12 error after reset", ctrl_err_o, 0);

    // R1 R2 R5 R10: table of known code words under forced disparity
    for (int v = 0; v < NVEC; v++) begin
      send_forced(VEC[v][20], VEC[v][19:12], VEC[v][11]);
      chk("R1 code word", code_o, wire_order(VEC[v][10:1]));
      chk("R2 disparity after forced word", disp_o, VEC[v][0]);
      chk("R5 valid", code_vld_o, 1);
      chk("R5 no control error", ctrl_err_o, 0);
    end

    // R3: three-cycle pipeline
    @(negedge clk);
    word_en_i = 1'b1; byte_i = 8'hB5;
    @(negedge clk);
    word_en_i = 1'b0;
    chk("R3 not valid after one edge", code_vld_o, 0);
    @(negedge clk);
    chk("R3 not valid after two edges", code_vld_o, 0);
    @(negedge clk);
    chk("R3 valid after three edges", code_vld_o, 1);
    chk("R3 code", code_o, wire_order(10'b1010101010));

    // R6: nonexistent control symbol K5.0 gives data encoding D5.0
    send_forced(1'b1, 8'h05, 1'b0);
    chk("R6 error flag", ctrl_err_o, 1);
    chk("R6 data code", code_o, wire_order(10'b1010011011));

    // R11: chain output within the cycle
    @(negedge clk);
    word_en_i = 1'b1; is_ctrl_i = 1'b1; byte_i = 8'hBC;
    @(negedge clk);
    word_en_i = 1'b0; is_ctrl_i = 1'b0;
    @(negedge clk);
    disp_force_i = 1'b1; disp_i = 1'b0;
    #1;
    chk("R11 chain output", disp_chain_o, 1);
    @(negedge clk);
    disp_force_i = 1'b0;
    chk("R11 registered disparity", disp_o, 1);

    // R9: idle cycles leave disparity alone
    repeat (5) @(negedge clk);
    chk("R9 no valid", code_vld_o, 0);
    chk("R9 disparity kept", disp_o, 1);

    // R7: comma fill, two words, starting from positive disparity
    fill_en_i = 1'b1;
    @(negedge clk);
    @(negedge clk);
    fill_en_i = 1'b0;
    @(negedge clk);
    chk("R7 first fill code", code_o, wire_order(10'b1100000101));
    chk("R7 first fill disparity", disp_o, 0);
    chk("R7 fill no error", ctrl_err_o, 0);
    @(negedge clk);
    chk("R7 second fill code", code_o, wire_order(10'b0011111010));
    chk("R7 second fill disparity", disp_o, 1);

    // R8: enable wins over fill
    fill_en_i = 1'b1;
    send_forced(1'b0, 8'hB5, 1'b0);
    fill_en_i = 1'b0;
    chk("R8 byte encoded, not comma", code_o, wire_order(10'b1010101010));

    // R4: unforced stream of three K28.5, starting from known disparity 0
    send_forced(1'b1, 8'h1C, 1'b0);  // K28.0 from negative leaves 0
    chk("R4 start disparity", disp_o, 0);
    @(negedge clk); word_en_i = 1'b1; is_ctrl_i = 1'b1; byte_i = 8'hBC;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk); word_en_i = 1'b0; is_ctrl_i = 1'b0;
    chk("R4 first word", code_o, wire_order(10'b0011111010));
    chk("R4 disparity 1", disp_o, 1);
    @(negedge clk);
    chk("R4 second word", code_o, wire_order(10'b1100000101));
    chk("R4 disparity 2", disp_o, 0);
    @(negedge clk);
    chk("R4 third word", code_o, wire_order(10'b0011111010));
    chk("R4 disparity 3", disp_o, 1);

    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule